// File: doc/BRIEF.md
# System-Control Exception Unit

This block holds the system-control registers of a small 32-bit MIPS-I style core: the processor state word (Status), the exception cause word (Cause), the saved return address (EPC) and a fixed processor identification word. When the core raises a synchronous exception, the block records why the exception happened and where it happened. It pushes the kernel/user and interrupt-enable stack, and it sends the fetch unit the vector address. A hardware interrupt is raised from an external interrupt status/mask pair whenever the interrupt gates in Status allow it.

Software reaches the registers through an index port that move-to and move-from coprocessor instructions use. Reads are combinational. Writes take effect at the next clock edge. A pop input restores the mode stack on the return path. The redirect output is a one-cycle control pulse with no back-pressure: the fetch unit must accept the address in the cycle that `redirect_valid` is high. No data stream crosses this block's edge, so it has no valid/ready handshake.

Top module: `sysctl_exc_unit`

## Requirements
- R1: While reset is asserted, `redirect_valid` is 1 and `redirect_pc` is 0xBFC00000. Status resets to 0x10900000, Cause to 0 and EPC to 0. `redirect_valid` drops to 0 at the first clock edge after reset is released.
- R2: On a synchronous exception, Cause becomes (old Cause AND 0x300) OR (code << 2), so the 5-bit code lands in Cause bits [6:2].
- R3: When the delay-slot flag is set, Cause bit 31 is set and EPC is loaded with PC - 4 (modulo 2^32). When the flag is clear, bit 31 stays clear and EPC is loaded with PC.
- R4: One clock after any exception is taken, `redirect_valid` is 1 for one cycle. `redirect_pc` is then 0xBFC00180 if Status bit 22 was 1 and 0x80000080 if it was 0.
- R5: On exception entry, Status bits [5:0] become the old bits [3:0] shifted left by two. Status bits [31:6] are unchanged.
- R6: A hardware interrupt is taken when (irq_status AND irq_mask) is nonzero and Status bits 10 and 0 are both 1. It sets Cause to (old Cause AND 0x300) OR 0x400, with bit 31 clear. It loads EPC with PC, and it pushes Status as in R5.
- R7: No interrupt is taken when (irq_status AND irq_mask) is zero, when Status bit 10 is 0 or when Status bit 0 is 0.
- R8: A synchronous exception in the same cycle as a pending interrupt wins, and Cause bit 10 is not set. The interrupt stays pending and is taken once the Status gates allow it again.
- R9: A pop pulse loads Status bits [3:0] from bits [5:2] and leaves all other bits unchanged.
- R10: The read port returns Status at index 12, Cause at 13, EPC at 14 and the constant 0x00000002 at 15. Every other index reads as 0.
- R11: A write to index 12 replaces all of Status. A write to index 13 changes only Cause bits [9:8]. Writes to indices 14 and 15 have no effect. When a write and an exception occur in the same cycle, the exception wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Synchronous exception request this cycle |
| exc_code | input | 5 | Exception code for Cause bits [6:2] |
| exc_in_delay | input | 1 | Faulting instruction is in a branch delay slot |
| cur_pc | input | 32 | PC of the current instruction |
| irq_status | input | IRQ_W | External interrupt status bits |
| irq_mask | input | IRQ_W | External interrupt mask bits |
| pop_stack | input | 1 | Restore the Status mode stack |
| reg_idx | input | 5 | Register index for read and write |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| redirect_valid | output | 1 | One-cycle fetch redirect pulse |
| redirect_pc | output | 32 | Redirect target address |

## Verification
The bench drives every exception code with and without the delay-slot flag, under both values of the vector-select bit and with a range of mode-stack patterns. Across this sweep it checks the arithmetic results. A design that kept the wrong Cause bits, or that put the code at the wrong offset, fails the Cause checks. A design that forgot the one-word backup, or lost the wrap at PC 0, fails the EPC checks. A stack that shifts by the wrong amount or in the wrong direction fails the Status checks. The interrupt gate is tested with each of the three conditions cleared in turn, so a gate that ignores one of them raises a spurious redirect. The priority test holds an interrupt across an exception, then pops the stack and expects the interrupt to be taken; a design that drops the pending interrupt, or merges the two causes, is caught there.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 5;
  localparam int CODE_W = 5;

  localparam logic [IDX_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [IDX_W-1:0] IDX_CAUSE  = 5'd13;
  localparam logic [IDX_W-1:0] IDX_EPC    = 5'd14;
  localparam logic [IDX_W-1:0] IDX_PRID   = 5'd15;

  localparam logic [XLEN-1:0] STATUS_RST  = 32'h1090_0000;
  localparam logic [XLEN-1:0] PRID_VAL    = 32'h0000_0002;
  localparam logic [XLEN-1:0] BOOT_PC     = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] VEC_ROM     = 32'hBFC0_0180;
  localparam logic [XLEN-1:0] VEC_RAM     = 32'h8000_0080;
  localparam logic [XLEN-1:0] CAUSE_SW    = 32'h0000_0300;
  localparam logic [XLEN-1:0] CAUSE_HWIP  = 32'h0000_0400;

  localparam int BEV_BIT  = 22;
  localparam int HWIM_BIT = 10;
  localparam int IE_BIT   = 0;
  localparam int BD_BIT   = 31;
  localparam int STK_W    = 6;

  typedef struct packed {
    logic              take;
    logic              is_irq;
    logic [CODE_W-1:0] code;
    logic              bd;
  } entry_t;
endpackage

// File: rtl/sc_exc_arbiter.sv
module sc_exc_arbiter
  import sysctl_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_in_delay,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              gate_hw,
  input  logic              gate_ie,
  output entry_t            ent
);
  logic irq_line;
  logic irq_ok;

  assign irq_line = |(irq_status & irq_mask);
  assign irq_ok   = irq_line & gate_hw & gate_ie;

  always_comb begin
    ent.take   = exc_req | irq_ok;
    ent.is_irq = ~exc_req & irq_ok;
    ent.code   = exc_req ? exc_code : '0;
    ent.bd     = exc_req & exc_in_delay;
  end
endmodule

// File: rtl/sc_status_stack.sv
module sc_status_stack
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  entry_t          ent,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wdata,
  input  logic            pop,
  output logic [XLEN-1:0] status
);
  localparam int KEEP_W = XLEN - STK_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      status <= STATUS_RST;
    else if (ent.take)
      status <= {status[XLEN-1:STK_W], status[STK_W-3:0], 2'b00};
    else if (wr_en)
      status <= wdata;
    else if (pop)
      status <= {status[XLEN-1:STK_W-2], status[STK_W-1:2]};
  end

  // R5
  push_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent.take |=> (status[STK_W-1:0] == {$past(status[STK_W-3:0]), 2'b00}) &&
                 (status[XLEN-1:STK_W] == $past(status[XLEN-1:STK_W])));

  // R9
  pop_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !ent.take && !wr_en) |=>
      (status[STK_W-3:0] == $past(status[STK_W-1:2])) &&
      (status[XLEN-1:STK_W-2] == $past(status[XLEN-1:STK_W-2])));

  logic [KEEP_W-1:0] unused_keep;
  assign unused_keep = status[XLEN-1:STK_W];
endmodule

// File: rtl/sc_cause_epc.sv
module sc_cause_epc
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  entry_t          ent,
  input  logic [XLEN-1:0] cur_pc,
  input  logic            wr_en,
  input  logic [1:0]      wdata_sw,
  output logic [XLEN-1:0] cause,
  output logic [XLEN-1:0] epc
);
  logic [XLEN-1:0] code_field;
  logic [XLEN-1:0] sw_field;

  assign code_field = ent.is_irq ? CAUSE_HWIP
                                 : {{(XLEN-CODE_W-2){1'b0}}, ent.code, 2'b00};
  assign sw_field   = {{(XLEN-10){1'b0}}, wdata_sw, 8'h00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      epc   <= '0;
    end else if (ent.take) begin
      cause         <= (cause & CAUSE_SW) | code_field;
      cause[BD_BIT] <= ent.bd;
      epc           <= ent.bd ? (cur_pc - XLEN'(4)) : cur_pc;
    end else if (wr_en) begin
      cause <= (cause & ~CAUSE_SW) | sw_field;
    end
  end

  // R3
  epc_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent.take && ent.bd) |=> (epc == $past(cur_pc) - 32'd4) && cause[BD_BIT]);

  // R11
  cause_wmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ent.take) |=> ((cause & ~CAUSE_SW) == $past(cause & ~CAUSE_SW)) &&
                             $stable(epc));
endmodule

// File: rtl/sc_redirect.sv
module sc_redirect
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            bev,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid <= 1'b1;
      redirect_pc    <= BOOT_PC;
    end else begin
      redirect_valid <= take;
      if (take) redirect_pc <= bev ? VEC_ROM : VEC_RAM;
    end
  end

  // R4
  redirect_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redirect_valid && (redirect_pc == ($past(bev) ? VEC_ROM : VEC_RAM)));
endmodule

// File: rtl/sysctl_exc_unit.sv
module sysctl_exc_unit
  import sysctl_pkg::*;
#(
  parameter int IRQ_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [4:0]        exc_code,
  input  logic              exc_in_delay,
  input  logic [31:0]       cur_pc,
  input  logic [IRQ_W-1:0]  irq_status,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              pop_stack,
  input  logic [4:0]        reg_idx,
  input  logic              reg_wr_en,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              redirect_valid,
  output logic [31:0]       redirect_pc
);
  entry_t          ent;
  logic [XLEN-1:0] status;
  logic [XLEN-1:0] cause;
  logic [XLEN-1:0] epc;
  logic            wr_status;
  logic            wr_cause;

  assign wr_status = reg_wr_en && (reg_idx == IDX_STATUS);
  assign wr_cause  = reg_wr_en && (reg_idx == IDX_CAUSE);

  sc_exc_arbiter #(.IRQ_W(IRQ_W)) u_arb (
    .exc_req      (exc_req),
    .exc_code     (exc_code),
    .exc_in_delay (exc_in_delay),
    .irq_status   (irq_status),
    .irq_mask     (irq_mask),
    .gate_hw      (status[HWIM_BIT]),
    .gate_ie      (status[IE_BIT]),
    .ent          (ent)
  );

  sc_status_stack u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .ent    (ent),
    .wr_en  (wr_status),
    .wdata  (reg_wdata),
    .pop    (pop_stack),
    .status (status)
  );

  sc_cause_epc u_cause (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent      (ent),
    .cur_pc   (cur_pc),
    .wr_en    (wr_cause),
    .wdata_sw (reg_wdata[9:8]),
    .cause    (cause),
    .epc      (epc)
  );

  sc_redirect u_redir (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (ent.take),
    .bev            (status[BEV_BIT]),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc)
  );

  always_comb begin
    unique case (reg_idx)
      IDX_STATUS: reg_rdata = status;
      IDX_CAUSE:  reg_rdata = cause;
      IDX_EPC:    reg_rdata = epc;
      IDX_PRID:   reg_rdata = PRID_VAL;
      default:    reg_rdata = '0;
    endcase
  end

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_req && !(status[HWIM_BIT] && status[IE_BIT])) |=> !redirect_valid);

  // R8
  sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |=> !cause[HWIM_BIT] && redirect_valid);
endmodule

// File: tb/test_sysctl_exc_unit.sv
module test_sysctl_exc_unit;
  localparam int IRQ_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             exc_req = 1'b0;
  logic [4:0]       exc_code = '0;
  logic             exc_in_delay = 1'b0;
  logic [31:0]      cur_pc = '0;
  logic [IRQ_W-1:0] irq_status = '0;
  logic [IRQ_W-1:0] irq_mask = '0;
  logic             pop_stack = 1'b0;
  logic [4:0]       reg_idx = '0;
  logic             reg_wr_en = 1'b0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic             redirect_valid;
  logic [31:0]      redirect_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_status, m_cause, m_epc, got;

  always #5 clk = ~clk;

  sysctl_exc_unit #(.IRQ_W(IRQ_W)) i_sysctl_exc_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] idx, output logic [31:0] val);
    reg_idx = idx;
    #1 val = reg_rdata;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [31:0] val);
    @(negedge clk);
    reg_idx = idx; reg_wdata = val; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    rd(5'd12, got); check({tag, " status"}, got, m_status);
    rd(5'd13, got); check({tag, " cause"},  got, m_cause);
    rd(5'd14, got); check({tag, " epc"},    got, m_epc);
  endtask

  function automatic logic [31:0] push(input logic [31:0] s);
    return {s[31:6], s[3:0], 2'b00};
  endfunction

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    // R1 reset state
    #12;
    check("R1 redirect_valid in reset", {31'b0, redirect_valid}, 32'd1);
    check("R1 boot pc", redirect_pc, 32'hBFC0_0000);
    m_status = 32'h1090_0000; m_cause = 0; m_epc = 0;
    check_regs("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 redirect drops", {31'b0, redirect_valid}, 32'd0);

    // R10 read map
    rd(5'd15, got); check("R10 prid", got, 32'h2);
    rd(5'd3,  got); check("R10 unmapped 3", got, 0);
    rd(5'd16, got); check("R10 unmapped 16", got, 0);

    // R11 write masking
    wr(5'd13, 32'hFFFF_FFFF); m_cause = 32'h300;
    wr(5'd14, 32'hDEAD_BEEF);
    wr(5'd15, 32'h1234_5678);
    check_regs("R11 masked writes");
    rd(5'd15, got); check("R11 prid read-only", got, 32'h2);

    // R2 R3 R4 R5 sweep: both vector selections, delay flag, every code
    for (int bev = 0; bev < 2; bev++)
      for (int bd = 0; bd < 2; bd++)
        for (int c = 0; c < 32; c++) begin
          logic [31:0] st, pc, sw;
          st = (bev != 0 ? 32'h1040_0000 : 32'h1000_0000) | ((c * 5 + bd * 3) & 32'h3f);
          sw = (c & 3) << 8;
          wr(5'd12, st); m_status = st;
          wr(5'd13, sw); m_cause = (m_cause & ~32'h300) | sw;
          pc = c * 32'h0101_0104;
          exc_req = 1'b1; exc_code = c[4:0]; exc_in_delay = bd[0]; cur_pc = pc;
          @(negedge clk);
          exc_req = 1'b0;
          m_cause = (m_cause & 32'h300) | (c << 2) | (bd != 0 ? 32'h8000_0000 : 0);
          m_epc = (bd != 0) ? pc - 32'd4 : pc;
          m_status = push(m_status);
          check("R4 redirect_valid", {31'b0, redirect_valid}, 32'd1);
          check("R4 vector", redirect_pc, bev != 0 ? 32'hBFC0_0180 : 32'h8000_0080);
          check_regs("R2/R3/R5 entry");
        end
    @(negedge clk);
    check("R4 one-cycle pulse", {31'b0, redirect_valid}, 32'd0);

    // R6 interrupt taken
    wr(5'd13, 32'h0000_0100); m_cause = (m_cause & ~32'h300) | 32'h100;
    wr(5'd12, 32'h0000_0401); m_status = 32'h401;
    irq_status = 11'h004; irq_mask = 11'h00C; cur_pc = 32'h8001_2340;
    @(negedge clk);
    m_cause = (m_cause & 32'h300) | 32'h400; m_epc = 32'h8001_2340;
    m_status = push(m_status);
    check("R6 irq redirect", {31'b0, redirect_valid}, 32'd1);
    check("R6 irq vector", redirect_pc, 32'h8000_0080);
    check_regs("R6 irq entry");
    @(negedge clk);
    check("R6 irq once after IE cleared", {31'b0, redirect_valid}, 32'd0);
    irq_status = '0; irq_mask = '0;

    // R7 gates
    wr(5'd12, 32'h0000_0401); m_status = 32'h401;
    irq_status = 11'h001; irq_mask = 11'h002;
    @(negedge clk); check("R7 masked off", {31'b0, redirect_valid}, 32'd0);
    irq_mask = 11'h001;
    wr(5'd12, 32'h0000_0400); m_status = 32'h400;
    check("R7 IE clear", {31'b0, redirect_valid}, 32'd0);
    wr(5'd12, 32'h0000_0001); m_status = 32'h1;
    check("R7 bit10 clear", {31'b0, redirect_valid}, 32'd0);
    @(negedge clk);
    check("R7 bit10 clear hold", {31'b0, redirect_valid}, 32'd0);
    check_regs("R7 untouched");
    irq_status = '0;

    // R8 priority, interrupt retaken after pop
    wr(5'd12, 32'h0040_0405); m_status = 32'h0040_0405;
    irq_status = 11'h400; irq_mask = 11'h7FF;
    exc_req = 1'b1; exc_code = 5'd8; exc_in_delay = 1'b0; cur_pc = 32'h0000_1000;
    @(negedge clk);
    exc_req = 1'b0;
    m_cause = (m_cause & 32'h300) | (32'd8 << 2); m_epc = 32'h1000;
    m_status = push(m_status);
    check("R8 sync wins redirect", {31'b0, redirect_valid}, 32'd1);
    check_regs("R8 sync wins");
    @(negedge clk);
    check("R8 irq held while IE 0", {31'b0, redirect_valid}, 32'd0);
    pop_stack = 1'b1;
    @(negedge clk);
    pop_stack = 1'b0;
    m_status = {m_status[31:4], m_status[5:2]};
    rd(5'd12, got); check("R9 pop restores", got, m_status);
    check("R8 not yet", {31'b0, redirect_valid}, 32'd0);
    cur_pc = 32'h0000_2000;
    @(negedge clk);
    m_cause = (m_cause & 32'h300) | 32'h400; m_epc = 32'h2000;
    m_status = push(m_status);
    check("R8 irq retaken", {31'b0, redirect_valid}, 32'd1);
    check("R8 irq vector", redirect_pc, 32'hBFC0_0180);
    check_regs("R8 irq retaken");
    irq_status = '0;

    // R9 pop alone
    wr(5'd12, 32'h0000_003A); m_status = 32'h3A;
    pop_stack = 1'b1;
    @(negedge clk);
    pop_stack = 1'b0;
    rd(5'd12, got); check("R9 pop bits", got, 32'h0000_003E);

    // R11 write loses to exception
    wr(5'd12, 32'h0000_0030); m_status = 32'h30;
    reg_idx = 5'd12; reg_wdata = 32'hFFFF_FFFF; reg_wr_en = 1'b1;
    exc_req = 1'b1; exc_code = 5'd4; exc_in_delay = 1'b0; cur_pc = 32'h44;
    @(negedge clk);
    reg_wr_en = 1'b0; exc_req = 1'b0;
    m_cause = (m_cause & 32'h300) | (32'd4 << 2); m_epc = 32'h44;
    m_status = push(m_status);
    check_regs("R11 exception over write");

    finish_run();
  end
endmodule